// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects interrupt events for a small microcontroller core and turns them into one request line and a fixed vector address for the CPU. There are three core sources: an external pin edge, a port-change event and a timer overflow. A second group of peripheral sources is split over two flag registers, with a matching pair of enable registers. Every source has a sticky flag, and the flag is set whenever its event fires, whatever the enable state. A request is raised only when the flag is qualified by its own enable bit. Peripheral sources must also pass a group enable, and every source must pass a global enable.

When the CPU acknowledges a request, hardware clears the global enable so that interrupts do not nest. A return strobe sets the global enable again. Flags are cleared only by software writes through a small register port. A flag left set therefore fires again as soon as interrupts are re-enabled. A wake-up output reports any enabled pending source and ignores the global enable, so a sleeping core can resume even with interrupts globally off.

The instruction cycle is modelled as four clock phases. The pin and port-change events are taken into their flags only on the first phase. The timer and peripheral events set their flags on the clock edge where they occur.

Top module: `irq_ctrl2`

## Requirements
- R1: A timer or peripheral event sets its flag on the clock edge where it is present, regardless of its own enable, the group enable (core bit 6) or the global enable (core bit 7).
- R2: After reset, every register reads 0 and `irq` and `wake` are 0. Register addresses are: 0 core, 1 peripheral flags A, 2 peripheral flags B, 3 peripheral enables A, 4 peripheral enables B. Core register bits are: 7 global enable, 6 group enable, 5/4/3 enables and 2/1/0 flags for timer/pin/port-change (`ev_core[2]`/`[1]`/`[0]`).
- R3: A phase counter starts at phase 0 on the first edge after reset and steps 0,1,2,3 once per clock. A pin or port-change event arriving at a phase-0 edge sets its flag on that edge. One arriving on phases 1 to 3 is held and sets its flag on the next phase-0 edge.
- R4: `irq` is high exactly when the global enable is set and either a core source has flag and enable set, or the group enable is set and a peripheral source has flag and enable set.
- R5: `irq_ack` clears the global enable on the next edge, so `irq` is low after it. `irq_vector` is always 0x0004.
- R6: `irq_ret` sets the global enable. If `irq_ack` and `irq_ret` occur in the same cycle, `irq_ack` wins. Both win over a software write of the core register in the same cycle.
- R7: Flags change only through register writes or events. When a write that clears a flag coincides with that flag's event, the flag ends up set.
- R8: A flag still set when `irq_ret` re-enables interrupts raises `irq` in the very next cycle.
- R9: `wake` is high when any core source has flag and enable set, or when the group enable is set and any peripheral source has flag and enable set. The global enable has no effect on it.
- R10: Reads from addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_core | input | 3 | Core events: [0] port change, [1] pin edge, [2] timer overflow |
| ev_pa | input | PA_W | Peripheral events of group A |
| ev_pb | input | PB_W | Peripheral events of group B |
| irq_ack | input | 1 | CPU takes the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request to CPU |
| irq_vector | output | VEC_W | Vector address, 0x0004 |
| wake | output | 1 | Wake-up from sleep |

## Verification
The request and wake logic is tried with a table of register settings. The table covers flags with and without their own enable, peripheral flags with and without the group enable, and every case with and without the global enable. Together these cases separate each gating level, and they separate `wake` from `irq`. Directed cases place a pin event on phase 0 and on phase 1, which separates immediate capture from the one-cycle-late hold. Further cases collide a flag clear with its event, and `irq_ack` with `irq_ret`, so that each priority is observed.

// File: rtl/irq_ctrl2.sv
module irq_ctrl2 #(
  parameter int PA_W = 8,
  parameter int PB_W = 1,
  parameter int VEC_W = 13,
  parameter logic [VEC_W-1:0] VECTOR = 'h4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       ev_core,
  input  logic [PA_W-1:0]  ev_pa,
  input  logic [PB_W-1:0]  ev_pb,
  input  logic             irq_ack,
  input  logic             irq_ret,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vector,
  output logic             wake
);
  localparam logic [2:0] A_CORE = 3'd0;
  localparam logic [2:0] A_PFA  = 3'd1;
  localparam logic [2:0] A_PFB  = 3'd2;
  localparam logic [2:0] A_PEA  = 3'd3;
  localparam logic [2:0] A_PEB  = 3'd4;

  logic [1:0]      phase;
  logic [1:0]      pend;
  logic [2:0]      core_flag, core_en;
  logic            gie, peie;
  logic [PA_W-1:0] pf_a, pe_a;
  logic [PB_W-1:0] pf_b, pe_b;

  wire q1     = (phase == 2'd0);
  wire wr_core = reg_wr && reg_addr == A_CORE;
  wire wr_pfa  = reg_wr && reg_addr == A_PFA;
  wire wr_pfb  = reg_wr && reg_addr == A_PFB;
  wire wr_pea  = reg_wr && reg_addr == A_PEA;
  wire wr_peb  = reg_wr && reg_addr == A_PEB;

  wire [2:0] hw_core = {ev_core[2], q1 ? (pend | ev_core[1:0]) : 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      pend      <= '0;
      core_flag <= '0;
      core_en   <= '0;
      gie       <= 1'b0;
      peie      <= 1'b0;
      pf_a      <= '0;
      pe_a      <= '0;
      pf_b      <= '0;
      pe_b      <= '0;
    end else begin
      phase     <= phase + 2'd1;
      pend      <= q1 ? 2'b00 : (pend | ev_core[1:0]);
      core_flag <= (wr_core ? reg_wdata[2:0] : core_flag) | hw_core;
      if (wr_core) begin
        core_en <= reg_wdata[5:3];
        peie    <= reg_wdata[6];
      end
      if (irq_ack)      gie <= 1'b0;
      else if (irq_ret) gie <= 1'b1;
      else if (wr_core) gie <= reg_wdata[7];
      pf_a <= (wr_pfa ? reg_wdata[PA_W-1:0] : pf_a) | ev_pa;
      pf_b <= (wr_pfb ? reg_wdata[PB_W-1:0] : pf_b) | ev_pb;
      if (wr_pea) pe_a <= reg_wdata[PA_W-1:0];
      if (wr_peb) pe_b <= reg_wdata[PB_W-1:0];
    end
  end

  wire core_hit  = |(core_flag & core_en);
  wire periph_hit = peie && (|(pf_a & pe_a) || |(pf_b & pe_b));

  assign wake       = core_hit || periph_hit;
  assign irq        = gie && wake;
  assign irq_vector = VECTOR;

  logic [7:0] rd_pfa, rd_pea, rd_pfb, rd_peb;
  always_comb begin
    rd_pfa = '0; rd_pfa[PA_W-1:0] = pf_a;
    rd_pea = '0; rd_pea[PA_W-1:0] = pe_a;
    rd_pfb = '0; rd_pfb[PB_W-1:0] = pf_b;
    rd_peb = '0; rd_peb[PB_W-1:0] = pe_b;
    case (reg_addr)
      A_CORE:  reg_rdata = {gie, peie, core_en, core_flag};
      A_PFA:   reg_rdata = rd_pfa;
      A_PFB:   reg_rdata = rd_pfb;
      A_PEA:   reg_rdata = rd_pea;
      A_PEB:   reg_rdata = rd_peb;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module irq_ctrl2_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic wake,
  input logic irq_ack,
  input logic irq_ret,
  input logic gie,
  input logic ev0,
  input logic flag0
);
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |=> !irq); // R5
  AST_RET_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n) (irq_ret && !irq_ack) |=> gie); // R6
  AST_NO_IRQ_WITHOUT_GIE: assert property (@(posedge clk) disable iff (!rst_n) !gie |-> !irq); // R4
  AST_IRQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> wake); // R9
  AST_PFLAG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n) ev0 |=> flag0); // R1
endmodule

bind irq_ctrl2 irq_ctrl2_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .wake(wake), .irq_ack(irq_ack),
  .irq_ret(irq_ret), .gie(gie), .ev0(ev_pa[0]), .flag0(pf_a[0])
);

// File: tb/irq_ctrl2_bench.sv
module irq_ctrl2_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ev_core = '0;
  logic [7:0]  ev_pa = '0;
  logic [0:0]  ev_pb = '0;
  logic        irq_ack = 1'b0, irq_ret = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq, wake;
  logic [12:0] irq_vector;

  int checks = 0, fails = 0, edges = 0;
  bit finished = 0;

  irq_ctrl2 u_irq_ctrl2 (
    .clk(clk), .rst_n(rst_n), .ev_core(ev_core), .ev_pa(ev_pa), .ev_pb(ev_pb),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .irq_vector(irq_vector), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  // {core, pflagA, penA, irq, wake}
  localparam logic [25:0] VEC [9] = '{
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    {8'h92, 8'h00, 8'h00, 1'b1, 1'b1},
    {8'h12, 8'h00, 8'h00, 1'b0, 1'b1},
    {8'h84, 8'h00, 8'h00, 1'b0, 1'b0},
    {8'h80, 8'h01, 8'h01, 1'b0, 1'b0},
    {8'hC0, 8'h01, 8'h01, 1'b1, 1'b1},
    {8'h40, 8'h80, 8'h80, 1'b0, 1'b1},
    {8'hC0, 8'h02, 8'h01, 1'b0, 1'b0},
    {8'hA9, 8'h00, 8'h00, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic align(input int ph);
    while ((edges % 4) != ph) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    // R2 reset state
    chk("R2 irq", irq, 0);
    chk("R2 wake", wake, 0);
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d); chk("R2 reg", d, 0);
    end
    chk("R5 vector", irq_vector, 13'h4);
    rd(3'd5, d); chk("R10 addr5", d, 0);
    rd(3'd7, d); chk("R10 addr7", d, 0);

    // R4/R9 table
    for (int i = 0; i < 9; i++) begin
      wr(3'd3, VEC[i][9:2]);
      wr(3'd1, VEC[i][17:10]);
      wr(3'd0, VEC[i][25:18]);
      chk("R4 irq table", irq, VEC[i][1]);
      chk("R9 wake table", wake, VEC[i][0]);
    end
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd3, 8'h00);

    // R1 flags latch with enables off
    ev_pa = 8'h08; step(); ev_pa = '0;
    rd(3'd1, d); chk("R1 pflagA", d, 8'h08);
    ev_pb = 1'b1; step(); ev_pb = '0;
    rd(3'd2, d); chk("R1 pflagB", d, 8'h01);
    ev_core = 3'b100; step(); ev_core = '0;
    rd(3'd0, d); chk("R1 timer flag", d, 8'h04);
    chk("R1 no irq", irq, 0);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);

    // R3 pin event on phase 0: immediate
    align(0);
    ev_core = 3'b010; step(); ev_core = '0;
    rd(3'd0, d); chk("R3 phase0 capture", d, 8'h02);
    wr(3'd0, 8'h00);
    // R3 pin event on phase 1: held to next phase 0
    align(1);
    ev_core = 3'b010; step(); ev_core = '0;
    rd(3'd0, d); chk("R3 held after event", d, 8'h00);
    step(); step();
    rd(3'd0, d); chk("R3 held before phase0", d, 8'h00);
    step();
    rd(3'd0, d); chk("R3 set at phase0", d, 8'h02);

    // R5 ack, R8 re-trigger, R6 priority
    wr(3'd0, 8'h92);
    chk("R5 irq before ack", irq, 1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk("R5 irq after ack", irq, 0);
    rd(3'd0, d); chk("R5 gie cleared", d[7], 0);
    irq_ret = 1'b1; step(); irq_ret = 1'b0;
    chk("R8 retrigger", irq, 1);
    irq_ack = 1'b1; irq_ret = 1'b1; step(); irq_ack = 1'b0; irq_ret = 1'b0;
    rd(3'd0, d); chk("R6 ack beats ret", d[7], 0);
    irq_ret = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h12; reg_wr = 1'b1;
    step(); irq_ret = 1'b0; reg_wr = 1'b0;
    rd(3'd0, d); chk("R6 ret beats write", d[7], 1);

    // R7 clear by write, and collision
    wr(3'd0, 8'h90);
    rd(3'd0, d); chk("R7 write clears", d, 8'h90);
    chk("R7 irq gone", irq, 0);
    ev_pa = 8'h04; reg_addr = 3'd1; reg_wdata = 8'h00; reg_wr = 1'b1;
    step(); ev_pa = '0; reg_wr = 1'b0;
    rd(3'd1, d); chk("R7 hw set wins", d, 8'h04);
    ev_core = 3'b100; reg_addr = 3'd0; reg_wdata = 8'h00; reg_wr = 1'b1;
    step(); ev_core = '0; reg_wr = 1'b0;
    rd(3'd0, d); chk("R7 timer hw wins", d, 8'h04);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule